// File: doc/BRIEF.md
# Dual-Channel Synchro Angle Loader with Fault Shutdown

This block sits between a byte-wide processor write bus and two digital-to-synchro converter channels. Each channel takes a 16-bit shaft angle, but the bus carries only eight bits at a time. The block stages each byte in a first-level buffer. The angle the converter sees changes only once the high byte has arrived. The converter then receives all 16 bits in one step, together with a one-cycle transfer strobe.

The block also watches the built-in-test flag of each converter. A shutdown-mode bit picks the response to a raised flag. In one mode only the power output stages and the rotor drive are turned off. In the other mode the whole converter circuit is shut down and an operator alert is raised. Either fault stays latched until software clears it while no flag is raised. Power-up of the two output stages is staggered: channel 0 comes up first, and channel 1 follows after a programmable number of clock cycles. This limits supply inrush.

Top module: `syn_angle_bus`

## Requirements
- R1: The two channels are independent. Address 0 holds the low byte of channel 0 and address 1 its high byte. Address 2 holds the low byte of channel 1 and address 3 its high byte. A channel's angle is {high byte, low byte}.
- R2: A low-byte write leaves the channel's angle output unchanged. A high-byte write makes the full 16-bit {high, low} value appear on the angle output one clock after the write edge.
- R3: The transfer strobe bit of a channel is high for exactly one cycle: the first cycle the new angle is visible. It is low at all other times.
- R4: A write to address 4 stores data bit 0 as the shutdown mode. With mode 1, a nonzero built-in-test flag on either channel drops both stage enables and the rotor enable to 0 from the next cycle. Circuit shutdown and alert stay 0.
- R5: With mode 0, a nonzero built-in-test flag raises circuit shutdown and alert from the next cycle, and all stage and rotor enables are 0.
- R6: A write to address 4 with data bit 1 set, while no fault is latched, raises stage enable 0 and the rotor enable on the next cycle. Stage enable 1 rises STAGGER+1 cycles after stage enable 0.
- R7: Faults stay latched. A write to address 4 with data bit 2 set clears them only while both test flags are 0, and is ignored otherwise. A start request is ignored while a fault is latched.
- R8: The stagger count is written at address 5 (low byte) and address 6 (high byte). After reset it is 16.
- R9: After reset, both angles are 0, all enables are 0, and circuit shutdown and alert are 0.
- R10: If a test flag causes a fault in the same cycle that the stagger count expires, the fault wins and stage enable 1 stays 0.
- R11: Faults and their clearing never change the angle outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data byte |
| bit_flag | input | 2 | Built-in-test flag per channel |
| ang0 | output | 16 | Latched angle for channel 0 |
| ang1 | output | 16 | Latched angle for channel 1 |
| xfer_pulse | output | 2 | One-cycle transfer strobe per channel |
| stage_en | output | 2 | Output-stage power enable per channel |
| rotor_en | output | 1 | Rotor drive enable |
| circuit_off | output | 1 | Whole-circuit shutdown |
| alert | output | 1 | Operator alert |

## Verification
The collision of interest is a test flag that rises in the very cycle the stagger counter would switch on the second output stage. The bench sets a short stagger, issues a start, and counts clocks so that the flag is raised just before the expiring edge. It then requires stage enable 1 to stay low and the mode-specific shutdown outputs to appear. Angle transfers are judged by a scoreboard. The scoreboard queues each expected 16-bit value and compares it in the cycle the transfer strobe fires, including transfers written while a fault is latched.

// File: rtl/syn_angle_bus.sv
module syn_angle_bus #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 3,
  parameter int STAG_DEF = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [1:0]          bit_flag,
  output logic [2*DATA_W-1:0] ang0,
  output logic [2*DATA_W-1:0] ang1,
  output logic [1:0]          xfer_pulse,
  output logic [1:0]          stage_en,
  output logic                rotor_en,
  output logic                circuit_off,
  output logic                alert
);
  localparam int ANG_W  = 2 * DATA_W;
  localparam int STAG_W = 2 * DATA_W;
  localparam int NCH    = 2;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_STGL = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_STGH = ADDR_W'(6);

  logic [ANG_W-1:0] ang_q [NCH];
  logic [1:0]       xfer_q;

  logic              mode_q, stage_flt, circ_flt;
  logic [1:0]        run_q;
  logic [STAG_W-1:0] stag_q, cnt_q;

  wire ctrl_wr  = wr_en && wr_addr == A_CTRL;
  wire flt_now  = |bit_flag;
  wire flt_held = stage_flt | circ_flt;
  wire clr_ok   = ctrl_wr && wr_data[2] && !flt_now;
  wire start_ok = ctrl_wr && wr_data[1] && !flt_held;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DATA_W-1:0] lo_buf, hi_buf;
    logic              pend;
    wire lo_wr = wr_en && wr_addr == ADDR_W'(2*c);
    wire hi_wr = wr_en && wr_addr == ADDR_W'(2*c+1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_buf    <= '0;
        hi_buf    <= '0;
        pend      <= 1'b0;
        ang_q[c]  <= '0;
        xfer_q[c] <= 1'b0;
      end else begin
        if (lo_wr) lo_buf <= wr_data;
        if (hi_wr) hi_buf <= wr_data;
        pend      <= hi_wr;
        xfer_q[c] <= pend;
        if (pend) ang_q[c] <= {hi_buf, lo_buf};
      end
    end

    AST_ANG_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (ang_q[c] != $past(ang_q[c])) |-> xfer_q[c]); // R3
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_q[c] |=> !xfer_q[c]); // R3
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      stag_q <= STAG_W'(STAG_DEF);
    end else begin
      if (ctrl_wr) mode_q <= wr_data[0];
      if (wr_en && wr_addr == A_STGL) stag_q[DATA_W-1:0] <= wr_data;
      if (wr_en && wr_addr == A_STGH) stag_q[STAG_W-1:DATA_W] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_flt <= 1'b0;
      circ_flt  <= 1'b0;
    end else if (clr_ok) begin
      stage_flt <= 1'b0;
      circ_flt  <= 1'b0;
    end else begin
      stage_flt <= stage_flt | (flt_now & mode_q);
      circ_flt  <= circ_flt | (flt_now & ~mode_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 2'b00;
      cnt_q <= '0;
    end else if (flt_now) begin
      run_q <= 2'b00;
      cnt_q <= '0;
    end else if (start_ok && !run_q[0]) begin
      run_q[0] <= 1'b1;
      cnt_q    <= stag_q;
    end else if (run_q[0] && !run_q[1]) begin
      if (cnt_q == '0) run_q[1] <= 1'b1;
      else             cnt_q    <= cnt_q - 1'b1;
    end
  end

  assign ang0        = ang_q[0];
  assign ang1        = ang_q[1];
  assign xfer_pulse  = xfer_q;
  assign stage_en    = run_q;
  assign rotor_en    = run_q[0];
  assign circuit_off = circ_flt;
  assign alert       = circ_flt;

  AST_STAGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    stage_en[1] |-> stage_en[0]); // R6
  AST_FLAG_KILLS_STAGES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(|bit_flag) |-> (stage_en == 2'b00 && !rotor_en)); // R4
  AST_ALERT_ONLY_MODE0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert) |-> !$past(mode_q)); // R5
  AST_NO_CLEAR_UNDER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (alert && (|bit_flag)) |=> alert); // R7
endmodule

// File: tb/syn_angle_bus_tb_top.sv
`timescale 1ns/1ps
module syn_angle_bus_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  bit_flag = '0;
  logic [15:0] ang0, ang1;
  logic [1:0]  xfer_pulse, stage_en;
  logic        rotor_en, circuit_off, alert;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [15:0] exp_q0[$];
  logic [15:0] exp_q1[$];

  always #4 clk = ~clk;

  syn_angle_bus dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bit_flag(bit_flag), .ang0(ang0), .ang1(ang1), .xfer_pulse(xfer_pulse),
    .stage_en(stage_en), .rotor_en(rotor_en), .circuit_off(circuit_off), .alert(alert)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic put_angle(input int ch, input logic [15:0] v);
    wr(3'(2*ch), v[7:0]);
    if (ch == 0) exp_q0.push_back(v); else exp_q1.push_back(v);
    wr(3'(2*ch+1), v[15:8]);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: R1 R2 R3
  always @(negedge clk) if (rst_n) begin
    if (xfer_pulse[0]) begin
      if (exp_q0.size() == 0) chk(1'b0, "R3 ch0 unexpected strobe", 32'(ang0), 32'h0);
      else begin
        logic [15:0] e;
        e = exp_q0.pop_front();
        chk(ang0 == e, "R2 ch0 angle", 32'(ang0), 32'(e));
      end
    end
    if (xfer_pulse[1]) begin
      if (exp_q1.size() == 0) chk(1'b0, "R3 ch1 unexpected strobe", 32'(ang1), 32'h0);
      else begin
        logic [15:0] e;
        e = exp_q1.pop_front();
        chk(ang1 == e, "R1 ch1 angle", 32'(ang1), 32'(e));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    idle(3);
    // R9 reset state
    chk(ang0 == 0 && ang1 == 0, "R9 angles", 32'({ang1, ang0}), 32'h0);
    chk(stage_en == 0 && !rotor_en, "R9 enables", 32'({rotor_en, stage_en}), 32'h0);
    chk(!circuit_off && !alert, "R9 shutdown", 32'({circuit_off, alert}), 32'h0);
    rst_n = 1'b1;
    idle(2);

    // R1 R2 R3 transfers
    put_angle(0, 16'h1234);
    chk(ang0 == 16'h0, "R2 not before transfer", 32'(ang0), 32'h0);
    idle(2);
    put_angle(1, 16'hBEEF);
    put_angle(0, 16'hFF00);
    put_angle(1, 16'h00FF);
    idle(3);
    chk(ang1 == 16'h00FF && ang0 == 16'hFF00, "R1 independent channels", 32'({ang1, ang0}), 32'h00FFFF00);

    // R2 low byte alone has no effect
    wr(3'd0, 8'hAA);
    idle(3);
    chk(ang0 == 16'hFF00, "R2 low byte only", 32'(ang0), 32'hFF00);
    exp_q0.push_back(16'h55AA);
    wr(3'd1, 8'h55);
    idle(2);

    // R6 R8 default stagger
    wr(3'd4, 8'h03);
    chk(stage_en == 2'b01 && rotor_en, "R6 stage0 first", 32'({rotor_en, stage_en}), 32'h5);
    n = 0;
    while (!stage_en[1] && n < 100) begin @(negedge clk); n++; end
    chk(n == 17, "R8 default stagger gap", 32'(n), 32'd17);

    // R4 mode 1 fault
    bit_flag = 2'b10;
    @(negedge clk);
    bit_flag = 2'b00;
    chk(stage_en == 0 && !rotor_en, "R4 stages off", 32'({rotor_en, stage_en}), 32'h0);
    chk(!circuit_off && !alert, "R4 no alert", 32'({circuit_off, alert}), 32'h0);
    wr(3'd4, 8'h03);
    idle(1);
    chk(stage_en == 0, "R7 start ignored while latched", 32'(stage_en), 32'h0);
    // R7 clear under flag ignored
    bit_flag = 2'b01;
    wr(3'd4, 8'h05);
    bit_flag = 2'b00;
    wr(3'd4, 8'h03);
    idle(1);
    chk(stage_en == 0, "R7 clear with flag ignored", 32'(stage_en), 32'h0);
    wr(3'd4, 8'h05);
    // R6 R8 programmed stagger 5
    wr(3'd5, 8'h05);
    wr(3'd6, 8'h00);
    wr(3'd4, 8'h03);
    chk(stage_en == 2'b01, "R7 start after clear", 32'(stage_en), 32'h1);
    n = 0;
    while (!stage_en[1] && n < 100) begin @(negedge clk); n++; end
    chk(n == 6, "R6 programmed stagger gap", 32'(n), 32'd6);

    // R5 R11 mode 0 fault
    wr(3'd4, 8'h00);
    bit_flag = 2'b01;
    @(negedge clk);
    bit_flag = 2'b00;
    chk(circuit_off && alert, "R5 circuit off and alert", 32'({circuit_off, alert}), 32'h3);
    chk(stage_en == 0 && !rotor_en, "R5 stages off", 32'({rotor_en, stage_en}), 32'h0);
    chk(ang0 == 16'h55AA && ang1 == 16'h00FF, "R11 angles kept", 32'({ang1, ang0}), 32'h00FF55AA);
    put_angle(1, 16'hC3A5);
    idle(2);
    bit_flag = 2'b11;
    wr(3'd4, 8'h04);
    bit_flag = 2'b00;
    idle(1);
    chk(alert, "R7 alert held under flag", 32'(alert), 32'h1);
    wr(3'd4, 8'h04);
    idle(1);
    chk(!alert && !circuit_off, "R7 cleared", 32'({circuit_off, alert}), 32'h0);
    chk(ang1 == 16'hC3A5, "R11 angle after clear", 32'(ang1), 32'hC3A5);

    // R10 fault on the expiry edge, mode 0
    wr(3'd5, 8'h04);
    wr(3'd4, 8'h02);
    idle(4);
    bit_flag = 2'b10;
    @(negedge clk);
    bit_flag = 2'b00;
    chk(stage_en == 0, "R10 fault beats stagger", 32'(stage_en), 32'h0);
    chk(alert && circuit_off, "R10 alert raised", 32'({circuit_off, alert}), 32'h3);
    idle(3);
    chk(stage_en == 0, "R10 stage1 stays off", 32'(stage_en), 32'h0);

    idle(3);
    chk(exp_q0.size() == 0 && exp_q1.size() == 0, "R3 all transfers seen",
        32'(exp_q0.size() + exp_q1.size()), 32'h0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule